// File: doc/BRIEF.md
# Lockable Real-Time Countdown Timer

This block is a byte-wide, memory-mapped countdown timer for a small microcontroller. Software writes a 16-bit reload value through a high and a low data register. Software then enables the timer and picks one of four clock-select codes. On each tick from the selected source the counter steps down by one. A tick that arrives while the counter is zero reloads it and sets a sticky flag. The flag drives a wake-up line. When the local interrupt enable and two external enables are all high, it also drives an interrupt request. That request is shared with a watchdog and is combined outside the block.

The clock-select field is protected while the timer runs. It can only be loaded by a control write made while the timer is stopped, and that same write may also start the timer. The timer state returns to its defaults only on the full reset (power-on or watchdog). The ordinary system reset clears only the registered bus read data, so the timer keeps counting through it. Clock sources appear as single-cycle tick enables in the one clock domain.

Top module: `rt_timer`

## Requirements
- R1: After a full reset (`por_n` or `wdt_rst_n` low), the control register reads 0x00, both count bytes read 0x00, `bus_rdata` is 0x00, and `irq_o` and `wake_o` are 0. Control bits: [0] run, [1] interrupt enable, [3:2] clock select, [7] flag. Other bits read 0.
- R2: Holding `sys_rst_n` low clears `bus_rdata` to 0x00. It does not change the control register, the reload value or the counter, and the counter keeps counting ticks during that reset.
- R3: While run is 1, a control write leaves the clock-select field unchanged, whatever value it carries.
- R4: A control write made while run is 0 loads the clock-select field and may set run in the same write.
- R5: After a write that clears run, a following write loads a new clock-select value.
- R6: Clock select 00 counts `tick_osc`. Select 01, 10 and 11 count the system tick: `tick_rc` when `cfg_use_rc` is 1, otherwise `tick_xdiv`.
- R7: With run at 1, each selected tick decrements a nonzero counter. A tick while the counter is 0 reloads the reload value and sets the flag.
- R8: The flag stays set until a control write with bit 7 at 0. A control write with bit 7 at 1 leaves it unchanged. A reload in the same cycle as a clearing write leaves the flag set.
- R9: `wake_o` follows the flag. `irq_o` is 1 only when the flag, the interrupt-enable bit, `shared_ien` and `global_ien` are all 1.
- R10: Registered read data appears one cycle after the read. Reading the low count byte (address 2) returns counter bits [7:0] and captures bits [15:8] into a shadow. Reading the high count byte (address 1) returns that shadow. The control register is at address 0.
- R11: With run at 0 the counter holds its value through ticks, and the flag is never set.
- R12: A data-register write while run is 0 loads both the reload byte and the counter byte. While run is 1 it loads only the reload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wdt_rst_n | input | 1 | Watchdog reset, active low, asynchronous |
| sys_rst_n | input | 1 | Ordinary system reset, active low; clears only the read path |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 count high, 2 count low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tick_osc | input | 1 | Primary oscillator tick enable |
| tick_xdiv | input | 1 | Divided crystal system tick enable |
| tick_rc | input | 1 | Internal RC system tick enable |
| cfg_use_rc | input | 1 | System tick taken from RC when 1 |
| shared_ien | input | 1 | Shared timer/watchdog interrupt enable |
| global_ien | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
A wrong clock select shows up at the next tick. The counter then moves on a tick it should ignore, or holds on a tick it should take, and the next low-byte read two cycles later exposes it. A corrupted counter or reload value surfaces on the next read or, at the latest, at the following wrap, where the flag, `wake_o` and the reloaded byte appear in the cycle after the zero tick. A lost lock or a wrong flag priority is visible at the control-register read issued just after the offending write. A shadow fault shows only on a high-byte read that follows a tick falling between the low and high reads.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int SRC_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_CNT_HI = 2'd1,
    REG_CNT_LO = 2'd2,
    REG_NONE   = 2'd3
  } rtt_reg_e;

  localparam int BIT_RUN    = 0;
  localparam int BIT_IE     = 1;
  localparam int BIT_SRC_LO = 2;
  localparam int BIT_FLAG   = 7;

  localparam logic [SRC_W-1:0] SRC_OSC = 2'b00;
endpackage

// File: rtl/rtt_rst_sync.sv
module rtt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = pipe_q[STAGES-1];
endmodule

// File: rtl/rtt_tick_sel.sv
module rtt_tick_sel
  import rtt_pkg::*;
(
  input  logic [SRC_W-1:0] src_sel,
  input  logic             tick_osc,
  input  logic             tick_xdiv,
  input  logic             tick_rc,
  input  logic             use_rc,
  output logic             tick
);
  logic sys_tick;

  always_comb begin
    sys_tick = use_rc ? tick_rc : tick_xdiv;
    tick     = (src_sel == SRC_OSC) ? tick_osc : sys_tick;
  end
endmodule

// File: rtl/rtt_counter.sv
module rtt_counter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count_o,
  output logic              wrap_o
);
  localparam int HI_LSB = CNT_W - DATA_W;

  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             at_zero;

  always_comb begin
    at_zero  = (count_q == '0);
    reload_d = reload_q;
    count_d  = count_q;
    wrap_o   = 1'b0;
    if (wr_hi) reload_d[CNT_W-1:HI_LSB] = wdata;
    if (wr_lo) reload_d[DATA_W-1:0]     = wdata;
    if (run) begin
      if (tick) begin
        if (at_zero) begin
          count_d = reload_q;
          wrap_o  = 1'b1;
        end else begin
          count_d = count_q - 1'b1;
        end
      end
    end else begin
      if (wr_hi) count_d[CNT_W-1:HI_LSB] = wdata;
      if (wr_lo) count_d[DATA_W-1:0]     = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
    end else begin
      count_q  <= count_d;
      reload_q <= reload_d;
    end
  end

  assign count_o = count_q;

  // R7: a zero tick while running brings back the stored reload value
  assert_reload_on_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && count_q == '0) |=> (count_q == $past(reload_q)));

  // R11: stopped and not written, the counter does not move
  assert_hold_when_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_hi && !wr_lo) |=> $stable(count_q));
endmodule

// File: rtl/rtt_ctrl.sv
module rtt_ctrl
  import rtt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wrap,
  output logic              run_o,
  output logic              ie_o,
  output logic [SRC_W-1:0]  src_o,
  output logic              flag_o
);
  logic             run_q, run_d;
  logic             ie_q, ie_d;
  logic [SRC_W-1:0] src_q, src_d;
  logic             flag_q, flag_d;
  logic             clr_req;

  always_comb begin
    run_d   = run_q;
    ie_d    = ie_q;
    src_d   = src_q;
    flag_d  = flag_q;
    clr_req = wr_ctrl && !wdata[BIT_FLAG];
    if (wr_ctrl) begin
      run_d = wdata[BIT_RUN];
      ie_d  = wdata[BIT_IE];
      if (!run_q) src_d = wdata[BIT_SRC_LO +: SRC_W];
    end
    if (clr_req) flag_d = 1'b0;
    if (wrap)    flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      src_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      ie_q   <= ie_d;
      src_q  <= src_d;
      flag_q <= flag_d;
    end
  end

  assign run_o  = run_q;
  assign ie_o   = ie_q;
  assign src_o  = src_q;
  assign flag_o = flag_q;

  // R3: select field frozen across any edge where the timer was running
  assert_src_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(src_q));

  // R8: only a clearing write can drop the flag
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_ctrl && !wdata[BIT_FLAG])) |=> flag_q);

  // R11: the flag rises only out of a running cycle
  assert_flag_needs_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(run_q));
endmodule

// File: rtl/rt_timer.sv
module rt_timer
  import rtt_pkg::*;
#(
  parameter int CNT_W     = 2 * DATA_W,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wdt_rst_n,
  input  logic              sys_rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_osc,
  input  logic              tick_xdiv,
  input  logic              tick_rc,
  input  logic              cfg_use_rc,
  input  logic              shared_ien,
  input  logic              global_ien,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int HI_LSB = CNT_W - DATA_W;

  logic full_srst_n, rd_srst_n;
  logic full_arst_n, rd_arst_n;

  assign full_arst_n = por_n & wdt_rst_n;
  assign rd_arst_n   = full_arst_n & sys_rst_n;

  rtt_rst_sync #(.STAGES(RST_STAGE)) u_sync_full (
    .clk(clk), .arst_n(full_arst_n), .srst_n(full_srst_n));
  rtt_rst_sync #(.STAGES(RST_STAGE)) u_sync_rd (
    .clk(clk), .arst_n(rd_arst_n), .srst_n(rd_srst_n));

  rtt_reg_e reg_sel;
  logic     acc_wr, acc_rd;
  logic     wr_ctrl, wr_hi, wr_lo, rd_lo;

  always_comb begin
    reg_sel = rtt_reg_e'(bus_addr);
    acc_wr  = bus_sel &&  bus_wr;
    acc_rd  = bus_sel && !bus_wr;
    wr_ctrl = acc_wr && (reg_sel == REG_CTRL);
    wr_hi   = acc_wr && (reg_sel == REG_CNT_HI);
    wr_lo   = acc_wr && (reg_sel == REG_CNT_LO);
    rd_lo   = acc_rd && (reg_sel == REG_CNT_LO);
  end

  logic             run, ie, flag, wrap, tick;
  logic [SRC_W-1:0] src;
  logic [CNT_W-1:0] count;

  rtt_ctrl u_ctrl (
    .clk(clk), .rst_n(full_srst_n), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
    .wrap(wrap), .run_o(run), .ie_o(ie), .src_o(src), .flag_o(flag));

  rtt_tick_sel u_tick (
    .src_sel(src), .tick_osc(tick_osc), .tick_xdiv(tick_xdiv),
    .tick_rc(tick_rc), .use_rc(cfg_use_rc), .tick(tick));

  rtt_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(full_srst_n), .run(run), .tick(tick),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wdata(bus_wdata),
    .count_o(count), .wrap_o(wrap));

  logic [DATA_W-1:0] shadow_q, shadow_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] ctrl_view;

  always_comb begin
    ctrl_view                          = '0;
    ctrl_view[BIT_RUN]                 = run;
    ctrl_view[BIT_IE]                  = ie;
    ctrl_view[BIT_SRC_LO +: SRC_W]     = src;
    ctrl_view[BIT_FLAG]                = flag;
    shadow_d = shadow_q;
    if (rd_lo) shadow_d = count[CNT_W-1:HI_LSB];
    rdata_d = rdata_q;
    if (acc_rd) begin
      unique case (reg_sel)
        REG_CTRL:   rdata_d = ctrl_view;
        REG_CNT_HI: rdata_d = shadow_q;
        REG_CNT_LO: rdata_d = count[DATA_W-1:0];
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge full_srst_n) begin
    if (!full_srst_n) shadow_q <= '0;
    else              shadow_q <= shadow_d;
  end

  always_ff @(posedge clk or negedge rd_srst_n) begin
    if (!rd_srst_n) rdata_q <= '0;
    else            rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign wake_o    = flag;
  assign irq_o     = flag & ie & shared_ien & global_ien;

  // R9: an interrupt is never raised without the wake-up line also high
  assert_irq_implies_wake_R9: assert property (@(posedge clk) disable iff (!full_srst_n)
    irq_o |-> wake_o);

  // R2: while the read path is in reset the read data stays cleared
  assert_rdata_cleared_R2: assert property (@(posedge clk)
    (!rd_srst_n) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_rt_timer.sv
module tb_rt_timer;
  logic       clk = 1'b0;
  logic       por_n, wdt_rst_n, sys_rst_n;
  logic       bus_sel, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       tick_osc, tick_xdiv, tick_rc, cfg_use_rc;
  logic       shared_ien, global_ien, irq_o, wake_o;

  always #2.5 clk = ~clk;

  rt_timer dut (
    .clk(clk), .por_n(por_n), .wdt_rst_n(wdt_rst_n), .sys_rst_n(sys_rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_osc(tick_osc), .tick_xdiv(tick_xdiv), .tick_rc(tick_rc),
    .cfg_use_rc(cfg_use_rc), .shared_ien(shared_ien), .global_ien(global_ien),
    .irq_o(irq_o), .wake_o(wake_o));

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int    checks = 0;
  int    errors = 0;
  logic  rd_seen = 1'b0;
  logic  done = 1'b0;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: compare the registered read data against the scoreboard
  always @(posedge clk) rd_seen <= bus_sel && !bus_wr;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected read result actual=%02h expected=none", bus_rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk(bus_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr_rc(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_rc = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_rc = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // which: 0 osc, 1 xdiv, 2 rc
  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (which == 0) tick_osc = 1'b1;
      else if (which == 1) tick_xdiv = 1'b1;
      else tick_rc = 1'b1;
      @(negedge clk);
      tick_osc = 1'b0; tick_xdiv = 1'b0; tick_rc = 1'b0;
    end
  endtask

  task automatic full_reset();
    @(negedge clk);
    por_n = 1'b0;
    repeat (4) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; wdt_rst_n = 1'b1; sys_rst_n = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    tick_osc = 1'b0; tick_xdiv = 1'b0; tick_rc = 1'b0; cfg_use_rc = 1'b0;
    shared_ien = 1'b0; global_ien = 1'b0;
    repeat (4) @(negedge clk);
    por_n = 1'b1; sys_rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 defaults
    chk(bus_rdata, 8'h00, "R1 rdata after reset");
    chk({6'd0, irq_o, wake_o}, 8'h00, "R1 irq/wake after reset");
    rd(2'd0, 8'h00, "R1 ctrl default");
    rd(2'd2, 8'h00, "R1 count lo default");
    rd(2'd1, 8'h00, "R1 count hi default");

    // R12 stopped: data writes load counter too
    wr(2'd2, 8'h03);
    wr(2'd1, 8'h00);
    rd(2'd2, 8'h03, "R12 lo loaded while stopped");
    rd(2'd1, 8'h00, "R12 hi loaded while stopped");

    // R4 select and run in one write
    wr(2'd0, 8'h05);
    rd(2'd0, 8'h05, "R4 select with run");

    // R6 source selection
    pulse(0, 2);
    rd(2'd2, 8'h03, "R6 osc ignored on system select");
    pulse(1, 1);
    rd(2'd2, 8'h02, "R6 xdiv counted");
    pulse(2, 1);
    rd(2'd2, 8'h02, "R6 rc ignored when cfg selects xdiv");
    cfg_use_rc = 1'b1;
    pulse(2, 2);
    rd(2'd2, 8'h00, "R7 decrement to zero");
    rd(2'd0, 8'h05, "R7 no flag on reaching zero");
    pulse(2, 1);
    rd(2'd2, 8'h03, "R7 reload on zero tick");
    rd(2'd0, 8'h85, "R7 flag set on wrap");

    // R9 gating
    chk({7'd0, wake_o}, 8'h01, "R9 wake follows flag");
    chk({7'd0, irq_o}, 8'h00, "R9 irq off without ie");
    wr(2'd0, 8'h87);
    shared_ien = 1'b1;
    @(negedge clk);
    chk({7'd0, irq_o}, 8'h00, "R9 irq off without global");
    global_ien = 1'b1;
    @(negedge clk);
    chk({7'd0, irq_o}, 8'h01, "R9 irq on all enables");

    // R3 lock
    wr(2'd0, 8'h8B);
    rd(2'd0, 8'h87, "R3 select locked while running");

    // R8 clear and priority
    wr(2'd0, 8'h07);
    rd(2'd0, 8'h07, "R8 clear by writing zero");
    chk({6'd0, irq_o, wake_o}, 8'h00, "R8 irq/wake drop on clear");
    pulse(2, 3);
    wr_rc(2'd0, 8'h07);
    rd(2'd0, 8'h87, "R8 set wins over clear");
    wr(2'd0, 8'h07);
    rd(2'd0, 8'h07, "R8 cleared again");

    // R5 stop then reselect
    wr(2'd0, 8'h06);
    rd(2'd0, 8'h06, "R5 stop keeps select");
    wr(2'd0, 8'h0A);
    rd(2'd0, 8'h0A, "R5 new select after stop");
    wr(2'd1, 8'h12);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h03);
    rd(2'd0, 8'h03, "R4 select osc with run");

    // R10 shadow
    rd(2'd2, 8'h00, "R10 lo read");
    pulse(0, 1);
    rd(2'd1, 8'h12, "R10 hi from shadow");
    rd(2'd2, 8'hFF, "R10 lo after tick");
    rd(2'd1, 8'h11, "R10 hi after tick");

    // R11 hold when stopped
    wr(2'd0, 8'h02);
    pulse(0, 3);
    rd(2'd2, 8'hFF, "R11 lo held when stopped");
    rd(2'd0, 8'h02, "R11 no flag when stopped");

    // R12 running: data writes leave counter
    wr(2'd0, 8'h03);
    wr(2'd2, 8'h05);
    rd(2'd2, 8'hFF, "R12 counter untouched while running");

    // R2 ordinary reset
    @(negedge clk);
    sys_rst_n = 1'b0;
    pulse(0, 1);
    chk(bus_rdata, 8'h00, "R2 rdata cleared by sys reset");
    sys_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bus_rdata, 8'h00, "R2 rdata stays clear after release");
    rd(2'd0, 8'h03, "R2 ctrl survives sys reset");
    rd(2'd2, 8'hFE, "R2 counted during sys reset");
    rd(2'd1, 8'h11, "R2 hi survives sys reset");

    // R1 full reset via watchdog
    @(negedge clk);
    wdt_rst_n = 1'b0;
    repeat (4) @(negedge clk);
    wdt_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd0, 8'h00, "R1 ctrl after watchdog reset");
    rd(2'd2, 8'h00, "R1 lo after watchdog reset");
    rd(2'd1, 8'h00, "R1 hi after watchdog reset");
    full_reset();
    rd(2'd0, 8'h00, "R1 ctrl after power-on reset");

    repeat (3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R10 pending reads actual=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule